// File: doc/BRIEF.md
# Sign-Extending 32-bit Word ALU

This unit performs 32-bit "word" arithmetic and shifts inside a 64-bit integer datapath. It takes two 64-bit operands and a 3-bit operation code. It computes add, subtract, logical left shift, logical right shift or arithmetic right shift on the low 32 bits only. It then widens the 32-bit answer to 64 bits by copying bit 31 into bits 63:32. Any carry or overflow past bit 31 is dropped, and the unit has no flag outputs.

By default the result passes through one output register. The register loads when `in_valid` is high, and `res_valid` reports one clock later that the register holds a fresh result. With `REG_OUT` set to 0, the result and valid pass straight through with no clock. The design has no state machine. The one piece of state is the output stage, which has two conditions: empty (after reset, or after a cycle with no input) and loaded (the cycle after an accepted operation).

Top module: `word_alu`

## Requirements
- R1: Operation code 3'b000 (add) gives the low 32 bits of operand A plus operand B, sign-extended from bit 31.
- R2: Operation code 3'b001 (subtract) gives the low 32 bits of A minus B, sign-extended from bit 31.
- R3: All three shifts use only `opnd_b[4:0]` as the shift count. Bits 63:5 of B have no effect on a shift result.
- R4: Operation code 3'b010 (left shift) shifts `opnd_a[31:0]` left with zero fill, keeps 32 bits, and sign-extends.
- R5: Operation code 3'b011 (logical right shift) shifts `opnd_a[31:0]` right with zero fill and sign-extends the 32-bit result. A zero shift of a value with bit 31 set gives ones in bits 63:32.
- R6: Operation code 3'b100 (arithmetic right shift) shifts `opnd_a[31:0]` right, filling with bit 31, and sign-extends.
- R7: Bits 63:32 of A never affect any result. Bits 63:32 of B never affect an add or subtract result.
- R8: `result[63:32]` always equals 32 copies of `result[31]`.
- R9: Operation codes 3'b101, 3'b110 and 3'b111 give a result of zero.
- R10: The output register loads on a rising edge where `in_valid` is 1. `res_valid` is 1 in exactly the cycle after each cycle where `in_valid` is 1.
- R11: After a cycle with `in_valid` at 0, `result` keeps its previous value.
- R12: A synchronous active-high `rst` clears `res_valid` and `result` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and code are valid this cycle |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 64 | First operand (shifted value, minuend) |
| opnd_b | input | 64 | Second operand (addend, subtrahend, shift count) |
| res_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Sign-extended 32-bit result |

## Verification
The bench tests the edges of the 32-bit field. It adds and subtracts across the 0x7FFFFFFF/0x80000000 boundary. If the design added in 64 bits, or took the sign from bit 63, it would put a wrong upper half on these cases. It shifts by 0, 1, 2, 30 and 31 with B's upper bits set to random values. A design that used six or more count bits, or that did a right shift over 64 bits, would pull A's upper bits into the result. The zero logical right shift of a negative word checks that bits 63:32 still fill with ones. Hold cycles, unused codes and a reset in the middle of the run check the register: a design that loaded when `in_valid` was low, or that left a result behind for an unused code, would show a stale or nonzero value.

// File: rtl/word_alu_pkg.sv
package word_alu_pkg;
    typedef enum logic [2:0] {
        WOP_ADD = 3'b000,
        WOP_SUB = 3'b001,
        WOP_SLL = 3'b010,
        WOP_SRL = 3'b011,
        WOP_SRA = 3'b100
    } wop_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'b00,
        SH_RLOG  = 2'b01,
        SH_RARI  = 2'b10
    } shmode_e;
endpackage

// File: rtl/word_addsub.sv
module word_addsub #(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] lhs,
    input  logic [WLEN-1:0] rhs,
    input  logic            do_sub,
    output logic [WLEN-1:0] sum
);
    logic [WLEN-1:0] rhs_eff;

    always_comb begin
        rhs_eff = do_sub ? ~rhs : rhs;
        sum     = lhs + rhs_eff + {{(WLEN-1){1'b0}}, do_sub};
    end
endmodule

// File: rtl/word_shifter.sv
module word_shifter
    import word_alu_pkg::*;
#(
    parameter int WLEN = 32,
    localparam int SHW = $clog2(WLEN)
) (
    input  logic [WLEN-1:0] din,
    input  logic [SHW-1:0]  amt,
    input  shmode_e         mode,
    output logic [WLEN-1:0] dout
);
    logic [WLEN-1:0] stg [0:SHW];
    logic [WLEN-1:0] din_rev;
    logic [WLEN-1:0] out_rev;
    logic            fill;

    always_comb begin
        for (int i = 0; i < WLEN; i++) begin
            din_rev[i] = din[WLEN-1-i];
        end
    end

    // Left shift is done as a right shift of the bit-reversed word.
    always_comb begin
        fill   = (mode == SH_RARI) ? din[WLEN-1] : 1'b0;
        stg[0] = (mode == SH_LEFT) ? din_rev : din;
    end

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        always_comb begin
            if (amt[s]) begin
                stg[s+1] = {{DIST{fill}}, stg[s][WLEN-1:DIST]};
            end else begin
                stg[s+1] = stg[s];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < WLEN; i++) begin
            out_rev[i] = stg[SHW][WLEN-1-i];
        end
        dout = (mode == SH_LEFT) ? out_rev : stg[SHW];
    end
endmodule

// File: rtl/word_alu.sv
module word_alu
    import word_alu_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int WLEN    = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [2:0]      op_sel,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            res_valid,
    output logic [XLEN-1:0] result
);
    localparam int SHW = $clog2(WLEN);
    localparam int EXT = XLEN - WLEN;

    wop_e            op;
    logic [WLEN-1:0] as_sum;
    logic [WLEN-1:0] sh_out;
    shmode_e         sh_mode;
    logic [WLEN-1:0] word;
    logic [XLEN-1:0] wide;

    assign op = wop_e'(op_sel);

    word_addsub #(.WLEN(WLEN)) u_addsub (
        .lhs    (opnd_a[WLEN-1:0]),
        .rhs    (opnd_b[WLEN-1:0]),
        .do_sub (op == WOP_SUB),
        .sum    (as_sum)
    );

    always_comb begin
        unique case (op)
            WOP_SLL: sh_mode = SH_LEFT;
            WOP_SRA: sh_mode = SH_RARI;
            default: sh_mode = SH_RLOG;
        endcase
    end

    word_shifter #(.WLEN(WLEN)) u_shift (
        .din  (opnd_a[WLEN-1:0]),
        .amt  (opnd_b[SHW-1:0]),
        .mode (sh_mode),
        .dout (sh_out)
    );

    always_comb begin
        unique case (op)
            WOP_ADD, WOP_SUB:          word = as_sum;
            WOP_SLL, WOP_SRL, WOP_SRA: word = sh_out;
            default:                   word = '0;
        endcase
        wide = {{EXT{word[WLEN-1]}}, word};
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_valid <= 1'b0;
                result    <= '0;
            end else begin
                res_valid <= in_valid;
                if (in_valid) begin
                    result <= wide;
                end
            end
        end

        // R10
        valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> res_valid);
        // R10
        valid_source_chk: assert property (@(posedge clk) disable iff (rst)
            res_valid |-> $past(in_valid));
        // R11
        hold_result_chk: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(result));
        // R9
        bad_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel > 3'd4) |=> (result == '0));
        // R1
        add_low_chk: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op_sel == 3'd0) |=>
            (result[WLEN-1:0] == $past(opnd_a[WLEN-1:0] + opnd_b[WLEN-1:0])));
        // R8
        sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
            result[XLEN-1:WLEN] == {EXT{result[WLEN-1]}});
    end else begin : g_comb
        assign res_valid = in_valid;
        assign result    = wide;
    end
endmodule

// File: tb/word_alu_bench.sv
module word_alu_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_sel;
    logic [63:0] opnd_a;
    logic [63:0] opnd_b;
    logic        res_valid;
    logic [63:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    word_alu u_word_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_valid(res_valid), .result(result)
    );

    function automatic logic [63:0] model(input logic [2:0] op,
                                          input logic [63:0] a,
                                          input logic [63:0] b);
        logic [31:0] w;
        logic [31:0] lo;
        int sh;
        lo = a[31:0];
        sh = int'(b[4:0]);
        case (op)
            3'd0: w = lo + b[31:0];
            3'd1: w = lo - b[31:0];
            3'd2: w = lo << sh;
            3'd3: w = lo >> sh;
            3'd4: w = 32'($signed(lo) >>> sh);
            default: return 64'd0;
        endcase
        return {{32{w[31]}}, w};
    endfunction

    function automatic string rtag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One accepted operation: drive at negedge, sample at the following negedge.
    task automatic run_op(input string req, input logic [2:0] op,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {63'd0, res_valid}, 64'd1);           // R10
        chk(req, result, model(op, a, b));
        chk("R8", result, {{32{result[31]}}, result[31:0]});
    endtask

    logic [63:0] ca [12];
    logic [63:0] cb [8];
    logic [63:0] keep;

    initial begin
        ca = '{64'd0, 64'd1, 64'd2, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000,
               64'h7FFF_FFFF_FFFF_FFFE, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
               64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF,
               64'h624B_3E97_6C52_DD14};
        cb = '{64'd0, 64'd1, 64'd2, 64'd30, 64'd31,
               64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF};
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        chk("R12 valid", {63'd0, res_valid}, 64'd0);
        chk("R12 result", result, 64'd0);

        // Directed corners on all five operations
        for (int op = 0; op < 5; op++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 8; j++) begin
                    run_op(rtag(3'(op)), 3'(op), ca[i], cb[j]);
                end
            end
        end

        // R5: zero logical right shift of a negative word fills upper half with ones
        run_op("R5", 3'd3, 64'h0000_0000_8000_0000, 64'd0);
        chk("R5 upper ones", result, 64'hFFFF_FFFF_8000_0000);

        // R3: shift count ignores B[63:5]
        for (int k = 0; k < 40; k++) begin
            logic [63:0] a;
            logic [63:0] bb;
            logic [2:0]  op;
            a  = {$urandom, $urandom};
            bb = {$urandom, $urandom};
            op = 3'(2 + (k % 3));
            run_op("R3", op, a, bb);
            chk("R3 count", result, model(op, a, {59'd0, bb[4:0]}));
        end

        // R7: upper bits of A (and of B for add/sub) do not matter
        for (int k = 0; k < 40; k++) begin
            logic [63:0] a;
            logic [63:0] bb;
            logic [2:0]  op;
            a  = {$urandom, $urandom};
            bb = {27'd0, $urandom} & 64'h0000_0000_FFFF_FFFF;
            op = 3'(k % 5);
            run_op("R7", op, a, bb);
            keep = result;
            run_op("R7", op, {~a[63:32], a[31:0]}, {$urandom, bb[31:0]} & (op < 2 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF));
            chk("R7 same", result, keep);
        end

        // R9: unused codes
        for (int c = 5; c < 8; c++) begin
            run_op("R9", 3'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF0);
            chk("R9 zero", result, 64'd0);
        end

        // Random mix
        for (int k = 0; k < 300; k++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            run_op(rtag(op), op, {$urandom, $urandom}, {$urandom, $urandom});
        end

        // R11 / R10: hold when in_valid low
        run_op("R1", 3'd0, 64'd5, 64'd7);
        keep = result;
        @(negedge clk);
        in_valid = 1'b0; op_sel = 3'd1; opnd_a = 64'hDEAD; opnd_b = 64'h1;
        @(negedge clk);
        chk("R10 idle valid", {63'd0, res_valid}, 64'd0);
        chk("R11 hold", result, keep);

        // R12: reset in mid run
        run_op("R2", 3'd1, 64'd1, 64'd3);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; op_sel = 3'd0; opnd_a = 64'd9; opnd_b = 64'd9;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        chk("R12 mid valid", {63'd0, res_valid}, 64'd0);
        chk("R12 mid result", result, 64'd0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule